// File: doc/BRIEF.md
# Pin-Banked GPIO Controller with Latched Interrupts

This block controls up to 96 general-purpose pins, of which 70 exist in the default build. Software reaches it through a small synchronous register port. The port has an address, a write strobe, write data, and read data that follows the address in the same cycle. Each per-pin setting is held in a group of 32-bit words called a feature. A feature spans three consecutive words, and each word covers 32 pins. The features are direction, drive value, interrupt mask, polarity, trigger kind and pending status.

Incoming pad levels pass through a two-stage synchronizer. The synchronized level is then compared with its previous sample to find edges. A pin can raise a level or an edge interrupt, and either kind can be active-high or active-low. The pending bit latches the event whether or not the pin is unmasked. Software clears a pending bit by writing one to it. Every pending pin that is also unmasked is merged onto a single interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zero and `irq_out` is low.
- R2: The word for pin n of a feature sits at base + 4*(n/32), and the pin is bit n%32 of that word. The bases are: direction 0x014, drive/value 0x024, mask 0x044, polarity 0x104, trigger kind 0x114, pending 0x124.
- R3: `pad_oe[n]` equals direction bit n, where 1 means output. `pad_out[n]` equals drive bit n. Both change on the clock edge that takes the write.
- R4: A read of the drive/value word returns the drive bit for output pins and the synchronized pad level for input pins.
- R5: A change on `pad_in` becomes visible in the value read after two rising clock edges, and not after one.
- R6: When trigger kind is 1 (edge), a pin sets its pending bit one edge after the synchronized level changes to the active value. Polarity 0 selects rising and polarity 1 selects falling. This happens even while the pin is masked.
- R7: When trigger kind is 0 (level), the pending bit is set in every cycle the synchronized level equals the active level (high for polarity 0, low for polarity 1). A write-one clear has no effect while that level persists.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_out` is high exactly when some pin has both its pending bit and its mask bit set.
- R10: Bits for pins 70 to 95 read 0 and ignore writes. Addresses that hit no feature word, including misaligned ones, read 0.
- R11: An edge event in the same cycle as a write-one clear of that pin leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 70 | Pad input levels, asynchronous |
| pad_out | output | 70 | Pad drive values |
| pad_oe | output | 70 | Pad output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
A corrupted direction or drive bit appears on `pad_oe` or `pad_out` on the edge after the write. A stale synchronizer stage or a wrong previous sample appears in the value read within two edges. It also appears as a pending bit that sets one edge too early, too late, or on the wrong edge direction. A wrong pending bit reaches `irq_out` in the same cycle the pin is unmasked. The bench keeps a behavioural model that steps in lock with every clock edge, so any of these faults is reported at the first clock edge where the model and the design disagree.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;
  localparam int BANK_IDX_W = 4;

  localparam logic [15:0] BASE_DIR = 16'h0014;
  localparam logic [15:0] BASE_DRV = 16'h0024;
  localparam logic [15:0] BASE_MSK = 16'h0044;
  localparam logic [15:0] BASE_POL = 16'h0104;
  localparam logic [15:0] BASE_KND = 16'h0114;
  localparam logic [15:0] BASE_PND = 16'h0124;

  typedef enum logic [2:0] {
    F_NONE, F_DIR, F_DRV, F_MSK, F_POL, F_KND, F_PND
  } feat_e;

  typedef struct packed {
    feat_e                 feat;
    logic [BANK_IDX_W-1:0] bank;
  } hit_t;

  // word index inside a feature window, or -1 when outside
  function automatic int word_in(input logic [15:0] a, input logic [15:0] base,
                                 input int nbanks);
    int off;
    off = int'(a) - int'(base);
    if (a[1:0] != 2'b00 || off < 0 || off >= 4 * nbanks) return -1;
    return off / 4;
  endfunction

  function automatic hit_t decode_addr(input logic [15:0] a, input int nbanks);
    hit_t h;
    int w;
    h = '{feat: F_NONE, bank: '0};
    w = word_in(a, BASE_DIR, nbanks); if (w >= 0) h = '{F_DIR, BANK_IDX_W'(w)};
    w = word_in(a, BASE_DRV, nbanks); if (w >= 0) h = '{F_DRV, BANK_IDX_W'(w)};
    w = word_in(a, BASE_MSK, nbanks); if (w >= 0) h = '{F_MSK, BANK_IDX_W'(w)};
    w = word_in(a, BASE_POL, nbanks); if (w >= 0) h = '{F_POL, BANK_IDX_W'(w)};
    w = word_in(a, BASE_KND, nbanks); if (w >= 0) h = '{F_KND, BANK_IDX_W'(w)};
    w = word_in(a, BASE_PND, nbanks); if (w >= 0) h = '{F_PND, BANK_IDX_W'(w)};
    return h;
  endfunction

  function automatic int pin_word(input int pin);
    return pin / WORD_W;
  endfunction

  function automatic int pin_bit(input int pin);
    return pin % WORD_W;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic kind_edge,
  input  logic pol_low,
  input  logic clr,
  output logic pend,
  output logic ev_set
);
  logic prev_q;
  logic pend_q;
  logic at_active;
  logic edge_hit;

  assign at_active = lvl ^ pol_low;
  assign edge_hit  = (lvl != prev_q) && at_active;
  assign ev_set    = kind_edge ? edge_hit : at_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= ev_set | (pend_q & ~clr);
    end
  end

  assign pend = pend_q;

  // R6 R11
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_edge && edge_hit) |=> pend_q);
  // R7
  level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kind_edge && at_active) |=> pend_q);
  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_set) |=> !pend_q);
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ev_set) |=> $stable(pend_q));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 70,
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_out
);
  localparam int SPAN   = NUM_BANKS * WORD_W;
  localparam int LOW_W  = (NUM_PINS < WORD_W) ? NUM_PINS : WORD_W;

  hit_t hit;
  assign hit = decode_addr(16'(bus_addr), NUM_BANKS);

  logic [NUM_PINS-1:0] dir_q, drv_q, msk_q, pol_q, knd_q;
  logic [NUM_PINS-1:0] pend_vec, set_vec, lvl_sync, pin_level;
  logic [NUM_PINS-1:0] in_bank, wbit;
  logic [NUM_PINS-1:0] m_dir, m_drv, m_msk, m_pol, m_knd, clr_vec;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(lvl_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WI = pin_word(p);
    localparam int BI = pin_bit(p);
    assign in_bank[p] = (int'(hit.bank) == WI);
    assign wbit[p]    = bus_wdata[BI];

    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_sync[p]),
      .kind_edge(knd_q[p]), .pol_low(pol_q[p]), .clr(clr_vec[p]),
      .pend(pend_vec[p]), .ev_set(set_vec[p])
    );
  end

  assign m_dir   = {NUM_PINS{bus_we && hit.feat == F_DIR}} & in_bank;
  assign m_drv   = {NUM_PINS{bus_we && hit.feat == F_DRV}} & in_bank;
  assign m_msk   = {NUM_PINS{bus_we && hit.feat == F_MSK}} & in_bank;
  assign m_pol   = {NUM_PINS{bus_we && hit.feat == F_POL}} & in_bank;
  assign m_knd   = {NUM_PINS{bus_we && hit.feat == F_KND}} & in_bank;
  assign clr_vec = {NUM_PINS{bus_we && hit.feat == F_PND}} & in_bank & wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
      msk_q <= '0;
      pol_q <= '0;
      knd_q <= '0;
    end else begin
      dir_q <= (dir_q & ~m_dir) | (wbit & m_dir);
      drv_q <= (drv_q & ~m_drv) | (wbit & m_drv);
      msk_q <= (msk_q & ~m_msk) | (wbit & m_msk);
      pol_q <= (pol_q & ~m_pol) | (wbit & m_pol);
      knd_q <= (knd_q & ~m_knd) | (wbit & m_knd);
    end
  end

  assign pin_level = (dir_q & drv_q) | (~dir_q & lvl_sync);
  assign pad_out   = drv_q;
  assign pad_oe    = dir_q;
  assign irq_out   = |(pend_vec & msk_q);

  logic [NUM_PINS-1:0] rd_src;
  logic [SPAN-1:0]     rd_wide;

  always_comb begin
    unique case (hit.feat)
      F_DIR:   rd_src = dir_q;
      F_DRV:   rd_src = pin_level;
      F_MSK:   rd_src = msk_q;
      F_POL:   rd_src = pol_q;
      F_KND:   rd_src = knd_q;
      F_PND:   rd_src = pend_vec;
      default: rd_src = '0;
    endcase
    rd_wide = '0;
    rd_wide[NUM_PINS-1:0] = rd_src;
    if (hit.feat == F_NONE) bus_rdata = '0;
    else bus_rdata = rd_wide[int'(hit.bank) * WORD_W +: WORD_W];
  end

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit.feat == F_DIR && hit.bank == '0)
      |=> pad_oe[LOW_W-1:0] == $past(bus_wdata[LOW_W-1:0]));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.feat == F_NONE) |-> bus_rdata == '0);
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NP = 70;
  localparam logic [11:0] A_DIR = 12'h014, A_DRV = 12'h024, A_MSK = 12'h044,
                          A_POL = 12'h104, A_KND = 12'h114, A_PND = 12'h124;

  logic clk = 0, rst_n = 0, bus_we = 0, irq_out;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  int checks = 0, errors = 0;
  bit running = 0;

  always #4 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // behavioural reference model, 96-bit feature images
  bit [95:0] m_dir, m_drv, m_msk, m_pol, m_knd, m_pnd, m_s1, m_s2, m_pv, nxt;

  function automatic bit [95:0] upd(bit [95:0] cur, logic [11:0] base,
                                    logic [11:0] a, logic [31:0] d);
    bit [95:0] r = cur;
    for (int b = 0; b < 3; b++)
      if (a == base + 12'(4 * b))
        for (int k = 0; k < 32; k++)
          if (32 * b + k < NP) r[32 * b + k] = d[k];
    return r;
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    bit [95:0] val = '0;
    for (int i = 0; i < NP; i++) val[i] = m_dir[i] ? m_drv[i] : m_s2[i];
    for (int b = 0; b < 3; b++) begin
      if (a == A_DIR + 12'(4 * b)) return m_dir[32 * b +: 32];
      if (a == A_DRV + 12'(4 * b)) return val[32 * b +: 32];
      if (a == A_MSK + 12'(4 * b)) return m_msk[32 * b +: 32];
      if (a == A_POL + 12'(4 * b)) return m_pol[32 * b +: 32];
      if (a == A_KND + 12'(4 * b)) return m_knd[32 * b +: 32];
      if (a == A_PND + 12'(4 * b)) return m_pnd[32 * b +: 32];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_dir, m_drv, m_msk, m_pol, m_knd, m_pnd, m_s1, m_s2, m_pv} = '0;
    end else begin
      nxt = '0;
      for (int i = 0; i < NP; i++) begin
        bit act, hit, clr;
        act = m_s2[i] ^ m_pol[i];
        hit = m_knd[i] ? (act && m_s2[i] != m_pv[i]) : act;
        clr = bus_we && bus_addr == A_PND + 12'(4 * (i / 32)) && bus_wdata[i % 32];
        nxt[i] = hit | (m_pnd[i] & ~clr);
      end
      if (bus_we) begin
        m_dir = upd(m_dir, A_DIR, bus_addr, bus_wdata);
        m_drv = upd(m_drv, A_DRV, bus_addr, bus_wdata);
        m_msk = upd(m_msk, A_MSK, bus_addr, bus_wdata);
        m_pol = upd(m_pol, A_POL, bus_addr, bus_wdata);
        m_knd = upd(m_knd, A_KND, bus_addr, bus_wdata);
      end
      m_pnd = nxt;
      m_pv = m_s2;
      m_s2 = m_s1;
      m_s1 = '0;
      m_s1[NP-1:0] = pad_in;
    end
  end

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // lock-step comparison every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (running && rst_n) begin
      chk("R3 pad_oe", 96'(pad_oe), 96'(m_dir[NP-1:0]));
      chk("R3 pad_out", 96'(pad_out), 96'(m_drv[NP-1:0]));
      chk("R9 irq_out", 96'(irq_out), 96'(|(m_pnd & m_msk)));
      chk("R2 R4 bus_rdata", 96'(bus_rdata), 96'(mread(bus_addr)));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    running = 1;
    tick(1);
    // R1 reset state
    for (int f = 0; f < 6; f++)
      for (int b = 0; b < 3; b++) begin
        logic [11:0] bs;
        bs = (f == 0) ? A_DIR : (f == 1) ? A_DRV : (f == 2) ? A_MSK :
             (f == 3) ? A_POL : (f == 4) ? A_KND : A_PND;
        rd(bs + 12'(4 * b), rv);
        chk("R1 reset reg", 96'(rv), 96'h0);
      end
    chk("R1 reset pad_oe", 96'(pad_oe), 96'h0);
    chk("R1 reset irq", 96'(irq_out), 96'h0);

    // R3 direction and drive
    wr(A_DIR, 32'h0000_00F0);
    wr(A_DRV, 32'hA5A5_A5A5);
    chk("R3 oe low word", 96'(pad_oe[31:0]), 96'h0000_00F0);
    chk("R3 out low word", 96'(pad_out[31:0]), 96'hA5A5_A5A5);
    // R4 mixed read
    rd(A_DRV, rv);
    chk("R4 value read", 96'(rv), 96'h0000_00A0);
    // R5 synchronizer latency
    pad_in[0] = 1'b1;
    tick(1); rd(A_DRV, rv);
    chk("R5 after one edge", 96'(rv), 96'h0000_00A0);
    tick(1); rd(A_DRV, rv);
    chk("R5 after two edges", 96'(rv), 96'h0000_00A1);

    // R10 unimplemented pins
    wr(A_DIR + 12'h8, 32'hFFFF_FFFF);
    wr(A_DRV + 12'h8, 32'hFFFF_FFFF);
    rd(A_DIR + 12'h8, rv);
    chk("R10 upper bits", 96'(rv), 96'h3F);
    chk("R10 pad_out top", 96'(pad_out[69:64]), 96'h3F);
    wr(A_DIR + 12'h8, 32'h0);

    // R6 R2 rising edge on pin 40 = word 1 bit 8, masked
    wr(A_KND + 12'h4, 32'h0000_0300);
    pad_in[40] = 1'b1;
    tick(2); rd(A_PND + 12'h4, rv);
    chk("R6 not yet", 96'(rv), 96'h0);
    tick(1); rd(A_PND + 12'h4, rv);
    chk("R6 rising sets", 96'(rv), 96'h100);
    chk("R9 masked quiet", 96'(irq_out), 96'h0);
    wr(A_MSK + 12'h4, 32'h0000_0100);
    chk("R9 unmasked fires", 96'(irq_out), 96'h1);
    wr(A_PND + 12'h4, 32'h0);
    rd(A_PND + 12'h4, rv);
    chk("R8 zero write keeps", 96'(rv), 96'h100);
    wr(A_PND + 12'h4, 32'h100);
    rd(A_PND + 12'h4, rv);
    chk("R8 one write clears", 96'(rv), 96'h0);
    chk("R9 cleared quiet", 96'(irq_out), 96'h0);
    // R6 falling edge
    wr(A_POL + 12'h4, 32'h0000_0100);
    pad_in[40] = 1'b0;
    tick(3); rd(A_PND + 12'h4, rv);
    chk("R6 falling sets", 96'(rv), 96'h100);
    chk("R9 falling irq", 96'(irq_out), 96'h1);
    wr(A_PND + 12'h4, 32'h100);

    // R11 edge on pin 41 coincides with a clear
    pad_in[41] = 1'b1;
    tick(2);
    wr(A_PND + 12'h4, 32'h200);
    rd(A_PND + 12'h4, rv);
    chk("R11 set beats clear", 96'(rv), 96'h200);
    wr(A_PND + 12'h4, 32'h200);
    rd(A_PND + 12'h4, rv);
    chk("R11 later clear", 96'(rv), 96'h0);

    // R7 level active-low on pin 65 = word 2 bit 1
    wr(A_POL + 12'h8, 32'h2);
    tick(1); rd(A_PND + 12'h8, rv);
    chk("R7 level sets", 96'(rv), 96'h2);
    wr(A_PND + 12'h8, 32'h2);
    rd(A_PND + 12'h8, rv);
    chk("R7 clear blocked", 96'(rv), 96'h2);
    pad_in[65] = 1'b1;
    tick(2); rd(A_PND + 12'h8, rv);
    chk("R7 latched after inactive", 96'(rv), 96'h2);
    wr(A_PND + 12'h8, 32'h2);
    rd(A_PND + 12'h8, rv);
    chk("R7 clear after inactive", 96'(rv), 96'h0);

    // R10 unmapped addresses
    rd(12'h000, rv); chk("R10 addr 000", 96'(rv), 96'h0);
    rd(12'h016, rv); chk("R10 misaligned", 96'(rv), 96'h0);
    rd(12'h050, rv); chk("R10 gap", 96'(rv), 96'h0);
    rd(12'h130, rv); chk("R10 past end", 96'(rv), 96'h0);
    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule